// File: doc/BRIEF.md
# Rational-Ratio Audio Clock Enable Generator

This block turns a reference clock into a stream of single-cycle enable pulses whose long-run rate is exactly N/M of the reference, with no accumulated rounding error. The N/M pair is looked up from a fixed table indexed by a 3-bit audio rate code. Downstream audio logic runs on the reference clock and advances one step per enable pulse. This gives the usual oversampled audio rates from a video-domain reference, with no second clock domain.

A trim mode moves the numerator one step down or up while the denominator stays the same. This speeds up or slows down the audio rate very slightly, so that audio can be kept in step with video. Any change of code or trim is taken at a clock edge. The phase accumulator keeps its value across the change, so the pulse stream never restarts.

The control is a three-state machine:
- `ST_LOAD` is the reset state. It captures the ratio and clears the accumulator.
- `ST_RUN` is the steady state.
- `ST_RETUNE` is entered whenever a newly captured ratio differs from the held one. In that cycle the accumulator is folded modulo the new denominator.

The transitions are LOAD→RUN (always), RUN→RUN (ratio unchanged), RUN→RETUNE (ratio changed), RETUNE→RUN (unchanged) and RETUNE→RETUNE (changed again).

Top module: `aclk_ratio_gen`

## Requirements
- R1: Codes 0, 1, 2 and 3 on `aud_sel` select N/M = 1024/2250, 1024/3375, 1024/4500 and 1024/6750.
- R2: Codes 4, 5 and 6 select N/M = 1568/3750, 1568/2500 and 1568/7500.
- R3: Code 7 selects N/M = 1024/1125.
- R4: With `trim_en`=1, the numerator is N-1 when `trim_up`=0 and N+1 when `trim_up`=1. M is unchanged in both cases.
- R5: While the ratio is held, every window of M consecutive cycles contains exactly N cycles with `ce_out`=1 (N is the trimmed numerator when trim is on).
- R6: On every edge outside the load state, the accumulator adds the numerator. When the sum is at least M, `ce_out` is 1 in the following cycle and the accumulator keeps the remainder modulo M. Otherwise `ce_out` is 0.
- R7: Inputs captured at one edge set the ratio used from the next edge on. The accumulator is never cleared by a ratio change. If a change leaves the sum at or above several multiples of the new M, it is reduced modulo M in one cycle and a single pulse is given.
- R8: While `rst_n`=0, and in the first cycle after its release, `ce_out` is 0 and the accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aud_sel | input | 3 | Audio rate code |
| trim_en | input | 1 | Enables the ±1 numerator trim |
| trim_up | input | 1 | Trim direction: 1 adds one, 0 subtracts one |
| ce_out | output | 1 | Clock-enable pulse, one cycle wide |

## Verification
The critical coincidence is a ratio change in the same cycle as an accumulator wrap. In that cycle the new denominator must fold a remainder left by the old, larger one, while a pulse is also due.

The bench provokes this by stepping through every code and trim setting in sequence. The step from code 6 (M=7500) to code 7 (M=1125) leaves large remainders that need several folds. The bench judges `ce_out` cycle by cycle against an arithmetic model of R6 and R7. It also counts pulses over a full M-cycle window for each setting.

// File: rtl/aclk_ratio_pkg.sv
package aclk_ratio_pkg;
    localparam int SEL_W = 3;
    localparam int NUM_W = 11;
    localparam int DEN_W = 13;
    localparam int ACC_W = DEN_W + 1;
    localparam int FOLD_STEPS = 8;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_RUN    = 2'd1,
        ST_RETUNE = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] den;
    } ratio_t;
endpackage

// File: rtl/aclk_ratio_table.sv
module aclk_ratio_table
    import aclk_ratio_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             trim_en,
    input  logic             trim_up,
    output ratio_t           ratio
);
    logic [NUM_W-1:0] base_num;

    always_comb begin
        base_num = NUM_W'(1024);
        ratio.den = DEN_W'(2250);
        unique case (sel)
            3'd0: ratio.den = DEN_W'(2250);
            3'd1: ratio.den = DEN_W'(3375);
            3'd2: ratio.den = DEN_W'(4500);
            3'd3: ratio.den = DEN_W'(6750);
            3'd4: begin base_num = NUM_W'(1568); ratio.den = DEN_W'(3750); end
            3'd5: begin base_num = NUM_W'(1568); ratio.den = DEN_W'(2500); end
            3'd6: begin base_num = NUM_W'(1568); ratio.den = DEN_W'(7500); end
            3'd7: ratio.den = DEN_W'(1125);
            default: ratio.den = DEN_W'(2250);
        endcase
        if (!trim_en)
            ratio.num = base_num;
        else if (trim_up)
            ratio.num = base_num + NUM_W'(1);
        else
            ratio.num = base_num - NUM_W'(1);
    end
endmodule

// File: rtl/aclk_ratio_ctrl.sv
module aclk_ratio_ctrl
    import aclk_ratio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ratio_t     live_ratio,
    output gen_state_e state,
    output ratio_t     held_ratio
);
    gen_state_e state_q, state_d;
    ratio_t     held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= live_ratio;
        end
    end

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_LOAD:   state_d = ST_RUN;
            ST_RUN:    state_d = (live_ratio != held_q) ? ST_RETUNE : ST_RUN;
            ST_RETUNE: state_d = (live_ratio != held_q) ? ST_RETUNE : ST_RUN;
            default:   state_d = ST_LOAD;
        endcase
    end

    assign state      = state_q;
    assign held_ratio = held_q;

    // R7: a changed ratio is always handled in the retune state
    a_r7_change_retunes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_LOAD && held_q != $past(held_q)) |-> state_q == ST_RETUNE);

    // R4: every trimmed or plain ratio stays below one
    a_r4_ratio_below_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOAD) |-> ({2'b00, held_q.num} < held_q.den));
endmodule

// File: rtl/aclk_phase_acc.sv
module aclk_phase_acc
    import aclk_ratio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gen_state_e state,
    input  ratio_t     ratio,
    output logic       ce
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] den_x;
    logic             wrap;
    logic [ACC_W-1:0] stage [FOLD_STEPS+1];

    assign den_x    = ACC_W'(ratio.den);
    assign sum      = acc_q + ACC_W'(ratio.num);
    assign wrap     = (sum >= den_x);
    assign stage[0] = sum;

    for (genvar i = 0; i < FOLD_STEPS; i++) begin : g_fold
        assign stage[i+1] = (stage[i] >= den_x) ? stage[i] - den_x : stage[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ce    <= 1'b0;
        end else begin
            unique case (state)
                ST_LOAD: begin
                    acc_q <= '0;
                    ce    <= 1'b0;
                end
                ST_RUN: begin
                    acc_q <= stage[1];
                    ce    <= wrap;
                end
                ST_RETUNE: begin
                    acc_q <= stage[FOLD_STEPS];
                    ce    <= wrap;
                end
                default: begin
                    acc_q <= '0;
                    ce    <= 1'b0;
                end
            endcase
        end
    end

    // R6: with a steady denominator the phase stays below it
    a_r6_acc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_LOAD && state != ST_LOAD && ratio.den == $past(ratio.den))
        |-> acc_q < den_x);

    // R8: the load state clears the phase and gives no pulse
    a_r8_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (acc_q == '0 && !ce));
endmodule

// File: rtl/aclk_ratio_gen.sv
module aclk_ratio_gen
    import aclk_ratio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] aud_sel,
    input  logic             trim_en,
    input  logic             trim_up,
    output logic             ce_out
);
    ratio_t     live_ratio;
    ratio_t     held_ratio;
    gen_state_e state;

    aclk_ratio_table u_table (
        .sel     (aud_sel),
        .trim_en (trim_en),
        .trim_up (trim_up),
        .ratio   (live_ratio)
    );

    aclk_ratio_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_ratio (live_ratio),
        .state      (state),
        .held_ratio (held_ratio)
    );

    aclk_phase_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .ratio (held_ratio),
        .ce    (ce_out)
    );
endmodule

// File: tb/tb_aclk_ratio_gen.sv
module tb_aclk_ratio_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       ten = 1'b0;
    logic       tup = 1'b0;
    logic       ce_out;

    int total = 0;
    int bad = 0;

    aclk_ratio_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .aud_sel (sel),
        .trim_en (ten),
        .trim_up (tup),
        .ce_out  (ce_out)
    );

    always #4 clk = ~clk;

    function automatic int exp_num(int s, bit e, bit u);
        int b = (s >= 4 && s <= 6) ? 1568 : 1024;
        if (e) b = u ? b + 1 : b - 1;
        return b;
    endfunction

    function automatic int exp_den(int s);
        case (s)
            0: return 2250;
            1: return 3375;
            2: return 4500;
            3: return 6750;
            4: return 3750;
            5: return 2500;
            6: return 7500;
            default: return 1125;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // arithmetic model of R6/R7/R8
    int m_num = 0, m_den = 1, m_acc = 0;
    bit m_ce = 0, m_started = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc <= 0; m_ce <= 0; m_started <= 0;
        end else if (!m_started) begin
            m_started <= 1; m_acc <= 0; m_ce <= 0;
            m_num <= exp_num(sel, ten, tup); m_den <= exp_den(sel);
        end else begin
            automatic int s = m_acc + m_num;
            m_ce  <= (s >= m_den);
            m_acc <= (s >= m_den) ? (s % m_den) : s;
            m_num <= exp_num(sel, ten, tup); m_den <= exp_den(sel);
        end
    end

    int mism = 0;
    int mism_act = 0;
    int mism_exp = 0;
    always @(negedge clk) begin
        if (rst_n && ce_out !== m_ce) begin
            if (mism == 0) begin mism_act = int'(ce_out); mism_exp = int'(m_ce); end
            mism++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ce_out == 1'b0, "R8 in reset", int'(ce_out), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(ce_out == 1'b0, "R8 load cycle", int'(ce_out), 0);
        @(posedge clk); @(negedge clk);
        check(ce_out == 1'b0, "R8 first run step", int'(ce_out), 0);
        for (int mode = 0; mode < 3; mode++) begin
            for (int s = 0; s < 8; s++) begin
                automatic int n, m, cnt = 0;
                automatic string tag;
                @(negedge clk);
                sel = 3'(s);
                ten = (mode != 0);
                tup = (mode == 2);
                mism = 0;
                n = exp_num(s, ten, tup);
                m = exp_den(s);
                @(posedge clk); @(posedge clk);
                for (int k = 0; k < m; k++) begin
                    @(posedge clk); @(negedge clk);
                    if (ce_out) cnt++;
                end
                if (mode != 0) tag = "R4 R5 trimmed window";
                else if (s <= 3) tag = "R1 R5 window";
                else if (s <= 6) tag = "R2 R5 window";
                else tag = "R3 R5 window";
                check(cnt == n, tag, cnt, n);
                check(mism == 0, "R6 R7 cycle-exact pulses", mism_act, mism_exp);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule